// File: doc/BRIEF.md
# Vector Interrupt Status and Pin Mapper

The block collects up to 256 edge-triggered interrupt vector lines into a bank of
pending bits. Each pending bit is qualified by a per-vector enable bit. The qualified
vectors are grouped 32 at a time, and each group is steered to one of a few
processor interrupt pins by a one-hot selection byte. Software uses a plain 32-bit
word read/write port. It programs the enables and the pin selection, reads status
words to find which vectors fired, and clears them by writing ones back. A spare
word bank is kept as plain read/write storage.

The vector count is a build parameter, 256 by default or 128 as the reduced option.
The pin count is also a parameter, 4 by default. Word addresses are byte offsets and
must be word aligned. Registers reset synchronously, on an active-high reset.

Top module: `vec_irq_mapper`

## Requirements
- R1: While reset is held and on the first cycle after it, every irq_pin bit is low and every status, enable, pin-select and storage word reads 0.
- R2: A 0-to-1 change on vec_in[v] sets the pending bit at bit v&31 of the status word at offset 0x1800+(v>>5)*4, whether or not the vector is enabled. An input that stays high does not set the bit again after a clear.
- R3: A write to a status word clears each pending bit whose write-data bit is 1 and leaves the bits written with 0 untouched.
- R4: When a rising input and a write-1 clear of the same bit land on the same clock edge, the bit ends up set.
- R5: The enable bit of vector v is bit v&31 of the word at offset 0x1600+(v>>5)*4. A written value reads back unchanged.
- R6: irq_pin[p] is high exactly when some group steered to pin p has a vector that is both pending and enabled. A pending vector whose enable is 0 raises no pin.
- R7: Group g (vectors 32g..32g+31) is steered by bits [8*(g&3)+7 : 8*(g&3)] of the word at offset 0x14C0+(g>>2)*4. A byte equal to 1<<p with p below the pin count selects pin p. A zero byte, a byte with several bits set, or a byte whose single bit is at or above the pin count selects no pin.
- R8: The storage words at offset 0x1680+(g*4) read back what was written and have no effect on any pin.
- R9: A read from an offset outside the four regions, or from an offset that is not word aligned, returns 0. Writes to such offsets change nothing.
- R10: bus_rdata shows the word for the offset presented one clock earlier. An input edge reaches irq_pin two edges after it is sampled. An enable, pin-select or status write reaches irq_pin one edge after the write commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_in | input | NUM_VEC | Interrupt vector lines, rising edge sensitive |
| bus_addr | input | 16 | Byte offset of the word accessed |
| bus_we | input | 1 | Write strobe for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's bus_addr |
| irq_pin | output | NUM_PINS | Processor interrupt pins, active high, bit p is pin p |

## Verification
Each result has a fixed due cycle. Read data is due one edge after the offset is driven. A pending bit can be read out starting from the edge after the input rises, and the matching pin changes one edge later. Pin changes caused by register writes appear one edge after the write commits. The driver tasks tag every expected value with its due cycle, counted from the driving negative edge. The monitor compares each value on the negative edge of exactly that cycle, so a result that comes early or late is caught, as well as a wrong value.

// File: rtl/vim_pkg.sv
package vim_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 16;
    localparam int WORD_VECS = 32;
    localparam int MAX_PINS  = 8;

    localparam logic [ADDR_W-1:0] PINSEL_BASE = 16'h14C0;
    localparam logic [ADDR_W-1:0] ENABLE_BASE = 16'h1600;
    localparam logic [ADDR_W-1:0] STORE_BASE  = 16'h1680;
    localparam logic [ADDR_W-1:0] STATUS_BASE = 16'h1800;

    typedef enum logic [2:0] {
        REG_NONE,
        REG_PINSEL,
        REG_ENABLE,
        REG_STORE,
        REG_STATUS
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    typedef struct packed {
        logic              we;
        reg_sel_t          sel;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    function automatic logic in_window(input int a, input logic [ADDR_W-1:0] base,
                                       input int words);
        return (a >= int'(base)) && (a < int'(base) + 4 * words);
    endfunction

    function automatic logic [7:0] word_index(input int a, input logic [ADDR_W-1:0] base);
        return 8'((a - int'(base)) >> 2);
    endfunction

    // Map a byte offset to a register region and word index.
    function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] addr,
                                             input int vec_words, input int sel_words);
        reg_sel_t s;
        int       a;
        s.kind = REG_NONE;
        s.idx  = '0;
        a      = int'(addr);
        if (addr[1:0] == 2'b00) begin
            if (in_window(a, PINSEL_BASE, sel_words)) begin
                s.kind = REG_PINSEL;
                s.idx  = word_index(a, PINSEL_BASE);
            end else if (in_window(a, ENABLE_BASE, vec_words)) begin
                s.kind = REG_ENABLE;
                s.idx  = word_index(a, ENABLE_BASE);
            end else if (in_window(a, STORE_BASE, vec_words)) begin
                s.kind = REG_STORE;
                s.idx  = word_index(a, STORE_BASE);
            end else if (in_window(a, STATUS_BASE, vec_words)) begin
                s.kind = REG_STATUS;
                s.idx  = word_index(a, STATUS_BASE);
            end
        end
        return s;
    endfunction

    // A selection byte picks a pin only if it has one bit set and that bit is a real pin.
    function automatic logic [MAX_PINS-1:0] decode_pin_byte(input logic [7:0] b,
                                                            input int npins);
        logic [7:0] lim;
        lim = 8'((1 << npins) - 1);
        if ($countones(b) == 1) return b & lim;
        return '0;
    endfunction

endpackage

// File: rtl/vim_pending_bank.sv
module vim_pending_bank
    import vim_pkg::*;
#(
    parameter int NUM_VEC = 256
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_VEC-1:0] vec_in,
    input  logic [NUM_VEC-1:0] clr_mask,
    output logic [NUM_VEC-1:0] pending
);

    localparam int VEC_WORDS = NUM_VEC / WORD_VECS;

    logic [NUM_VEC-1:0] vec_q;
    logic [NUM_VEC-1:0] rise;

    assign rise = vec_in & ~vec_q;

    // Per word: clear first, then the edge sets, so a same-edge set wins.
    for (genvar w = 0; w < VEC_WORDS; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                vec_q[w*WORD_VECS +: WORD_VECS]   <= '0;
                pending[w*WORD_VECS +: WORD_VECS] <= '0;
            end else begin
                vec_q[w*WORD_VECS +: WORD_VECS]   <= vec_in[w*WORD_VECS +: WORD_VECS];
                pending[w*WORD_VECS +: WORD_VECS] <=
                    (pending[w*WORD_VECS +: WORD_VECS] & ~clr_mask[w*WORD_VECS +: WORD_VECS])
                    | rise[w*WORD_VECS +: WORD_VECS];
            end
        end
    end

endmodule

// File: rtl/vim_cfg_regs.sv
module vim_cfg_regs
    import vim_pkg::*;
#(
    parameter int VEC_WORDS = 8,
    parameter int SEL_WORDS = 2
) (
    input  logic                                clk,
    input  logic                                rst,
    input  bus_req_t                            req,
    output logic [VEC_WORDS-1:0][DATA_W-1:0]    en_words,
    output logic [VEC_WORDS-1:0][DATA_W-1:0]    store_words,
    output logic [SEL_WORDS-1:0][DATA_W-1:0]    sel_words
);

    function automatic logic hit(input bus_req_t r, input reg_kind_e k, input int w);
        return r.we && (r.sel.kind == k) && (r.sel.idx == 8'(w));
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            en_words    <= '0;
            store_words <= '0;
        end else begin
            for (int w = 0; w < VEC_WORDS; w++) begin
                if (hit(req, REG_ENABLE, w)) en_words[w]    <= req.data;
                if (hit(req, REG_STORE, w))  store_words[w] <= req.data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_words <= '0;
        end else begin
            for (int w = 0; w < SEL_WORDS; w++) begin
                if (hit(req, REG_PINSEL, w)) sel_words[w] <= req.data;
            end
        end
    end

endmodule

// File: rtl/vim_pin_router.sv
module vim_pin_router
    import vim_pkg::*;
#(
    parameter int NUM_GRP   = 8,
    parameter int SEL_WORDS = 2,
    parameter int NUM_PINS  = 4
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [NUM_GRP*WORD_VECS-1:0]         pending,
    input  logic [NUM_GRP*WORD_VECS-1:0]         enable,
    input  logic [SEL_WORDS-1:0][DATA_W-1:0]     sel_words,
    output logic [NUM_PINS-1:0]                  irq_pin
);

    logic                grp_act  [NUM_GRP];
    logic [NUM_PINS-1:0] grp_pins [NUM_GRP];
    logic [NUM_PINS-1:0] pin_next;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        assign grp_act[g]  = |(pending[g*WORD_VECS +: WORD_VECS] &
                               enable[g*WORD_VECS +: WORD_VECS]);
        assign grp_pins[g] = NUM_PINS'(decode_pin_byte(sel_words[g/4][8*(g%4) +: 8],
                                                       NUM_PINS));
    end

    always_comb begin
        pin_next = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (grp_act[g]) pin_next = pin_next | grp_pins[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq_pin <= '0;
        else     irq_pin <= pin_next;
    end

endmodule

// File: rtl/vec_irq_mapper.sv
module vec_irq_mapper
    import vim_pkg::*;
#(
    parameter int NUM_VEC  = 256,
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_VEC-1:0]  vec_in,
    input  logic [15:0]         bus_addr,
    input  logic                bus_we,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic [NUM_PINS-1:0] irq_pin
);

    localparam int VEC_WORDS = NUM_VEC / WORD_VECS;
    localparam int SEL_WORDS = (VEC_WORDS + 3) / 4;

    bus_req_t                          req;
    logic [NUM_VEC-1:0]                clr_mask;
    logic [NUM_VEC-1:0]                pending;
    logic [NUM_VEC-1:0]                enable_flat;
    logic [VEC_WORDS-1:0][DATA_W-1:0]  pend_words;
    logic [VEC_WORDS-1:0][DATA_W-1:0]  en_words;
    logic [VEC_WORDS-1:0][DATA_W-1:0]  store_words;
    logic [SEL_WORDS-1:0][DATA_W-1:0]  sel_words;
    logic [DATA_W-1:0]                 rd_next;

    always_comb begin
        req.we   = bus_we;
        req.sel  = decode_addr(bus_addr, VEC_WORDS, SEL_WORDS);
        req.data = bus_wdata;
    end

    // Write-1-to-clear mask for the addressed status word.
    always_comb begin
        clr_mask = '0;
        if (req.we && req.sel.kind == REG_STATUS) begin
            for (int w = 0; w < VEC_WORDS; w++) begin
                if (req.sel.idx == 8'(w)) clr_mask[w*WORD_VECS +: WORD_VECS] = req.data;
            end
        end
    end

    vim_pending_bank #(.NUM_VEC(NUM_VEC)) u_pend (
        .clk      (clk),
        .rst      (rst),
        .vec_in   (vec_in),
        .clr_mask (clr_mask),
        .pending  (pending)
    );

    vim_cfg_regs #(.VEC_WORDS(VEC_WORDS), .SEL_WORDS(SEL_WORDS)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .req         (req),
        .en_words    (en_words),
        .store_words (store_words),
        .sel_words   (sel_words)
    );

    assign enable_flat = en_words;
    assign pend_words  = pending;

    vim_pin_router #(.NUM_GRP(VEC_WORDS), .SEL_WORDS(SEL_WORDS), .NUM_PINS(NUM_PINS)) u_route (
        .clk       (clk),
        .rst       (rst),
        .pending   (pending),
        .enable    (enable_flat),
        .sel_words (sel_words),
        .irq_pin   (irq_pin)
    );

    always_comb begin
        rd_next = '0;
        for (int w = 0; w < VEC_WORDS; w++) begin
            if (req.sel.idx == 8'(w)) begin
                case (req.sel.kind)
                    REG_ENABLE: rd_next = en_words[w];
                    REG_STORE:  rd_next = store_words[w];
                    REG_STATUS: rd_next = pend_words[w];
                    default:    ;
                endcase
            end
        end
        for (int w = 0; w < SEL_WORDS; w++) begin
            if (req.sel.kind == REG_PINSEL && req.sel.idx == 8'(w)) rd_next = sel_words[w];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_next;
    end

endmodule

// File: rtl/vim_chk.sv
module vim_chk #(
    parameter int NUM_VEC  = 256,
    parameter int NUM_PINS = 4
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_VEC-1:0]  vec_in,
    input logic [NUM_VEC-1:0]  pending,
    input logic [NUM_VEC-1:0]  enable_flat,
    input logic [NUM_VEC-1:0]  clr_mask,
    input logic [NUM_PINS-1:0] irq_pin
);

    logic [NUM_VEC-1:0] vin_d;
    logic [NUM_VEC-1:0] rise_c;

    always_ff @(posedge clk) begin
        if (rst) vin_d <= '0;
        else     vin_d <= vec_in;
    end

    assign rise_c = vec_in & ~vin_d;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $fell(rst) |-> (pending == '0 && irq_pin == '0));

    // R2
    edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|rise_c) |=> ((pending & $past(rise_c)) == $past(rise_c)));

    // R2
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
        (pending & ~$past(pending) & ~$past(rise_c)) == '0);

    // R3
    clear_done_chk: assert property (@(posedge clk) disable iff (rst)
        (|clr_mask) |=> ((pending & $past(clr_mask & ~rise_c)) == '0));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (|(clr_mask & rise_c)) |=> ((pending & $past(clr_mask & rise_c)) == $past(clr_mask & rise_c)));

    // R6
    masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((pending & enable_flat) == '0) |=> (irq_pin == '0));

endmodule

bind vec_irq_mapper vim_chk #(.NUM_VEC(NUM_VEC), .NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .vec_in      (vec_in),
    .pending     (pending),
    .enable_flat (enable_flat),
    .clr_mask    (clr_mask),
    .irq_pin     (irq_pin)
);

// File: tb/tb_vec_irq_mapper.sv
module tb_vec_irq_mapper;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 256;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NV-1:0] vec_in = '0;
    logic [15:0]   bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] irq_pin;

    int  cyc = 0;
    int  checks = 0;
    int  failures = 0;
    bit  done = 1'b0;

    typedef struct {
        int          due;
        bit          is_pin;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    vec_irq_mapper #(.NUM_VEC(NV), .NUM_PINS(NP)) dut (
        .clk       (clk),
        .rst       (rst),
        .vec_in    (vec_in),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pin   (irq_pin)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare every item that falls due on this negative edge.
    always @(negedge clk) begin
        for (int i = sb_q.size() - 1; i >= 0; i--) begin
            if (sb_q[i].due == cyc) begin
                logic [31:0] act;
                act = sb_q[i].is_pin ? {{(32-NP){1'b0}}, irq_pin} : bus_rdata;
                checks++;
                if (act !== sb_q[i].exp) begin
                    failures++;
                    $display("FAIL %s %s actual=%h expected=%h", sb_q[i].req,
                             sb_q[i].is_pin ? "pins" : "rdata", act, sb_q[i].exp);
                end
                sb_q.delete(i);
            end
        end
    end

    task automatic push(input bit is_pin, input logic [31:0] exp, input int dly, input string req);
        item_t it;
        it.due = cyc + dly; it.is_pin = is_pin; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        push(1'b0, exp, 1, req);
    endtask

    task automatic pin_exp(input logic [NP-1:0] exp, input int dly, input string req);
        push(1'b1, {{(32-NP){1'b0}}, exp}, dly, req);
    endtask

    task automatic vec_up(input int v);
        @(negedge clk);
        vec_in[v] = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        pin_exp(4'h0, 1, "R1");
        rd_chk(16'h1600, 32'h0, "R1");
        rd_chk(16'h1800, 32'h0, "R1");
        rd_chk(16'h14C0, 32'h0, "R1");
        rd_chk(16'h1680, 32'h0, "R1");

        // R7: groups 0..3 -> pins 0..3, group4 -> pin0, 5 multi-bit, 6 out of range, 7 none
        wr(16'h14C0, 32'h0804_0201);
        wr(16'h14C4, 32'h0010_0301);
        rd_chk(16'h14C0, 32'h0804_0201, "R7");
        rd_chk(16'h14C4, 32'h0010_0301, "R7");

        // R2 / R6: edge on a disabled vector sets status, no pin
        vec_up(3);
        pin_exp(4'h0, 2, "R6");
        rd_chk(16'h1800, 32'h0000_0008, "R2");

        // R5: enable word, pin rises one edge after the write
        wr(16'h1600, 32'hFFFF_FFFF);
        pin_exp(4'h1, 1, "R5");
        rd_chk(16'h1600, 32'hFFFF_FFFF, "R5");

        // R6: mask only vector 3
        wr(16'h1600, 32'hFFFF_FFF7);
        pin_exp(4'h0, 1, "R6");
        rd_chk(16'h1800, 32'h0000_0008, "R6");

        // R3 / R2: clear, held-high input does not re-set
        wr(16'h1800, 32'h0000_0008);
        rd_chk(16'h1800, 32'h0, "R3");
        wr(16'h1600, 32'hFFFF_FFFF);
        pin_exp(4'h0, 1, "R3");
        rd_chk(16'h1800, 32'h0, "R2");

        // R10: edge to pin takes two edges
        wr(16'h1608, 32'hFFFF_FFFF);
        vec_up(70);
        pin_exp(4'h0, 1, "R10");
        pin_exp(4'h4, 2, "R10");

        // R4: edge of vector 71 on the same edge as clearing bits 6 and 7
        @(negedge clk);
        vec_in[71] = 1'b1;
        bus_we = 1'b1; bus_addr = 16'h1808; bus_wdata = 32'h0000_00C0;
        @(negedge clk);
        bus_we = 1'b0;
        pin_exp(4'h4, 1, "R4");
        rd_chk(16'h1808, 32'h0000_0080, "R4");

        wr(16'h1808, 32'h0000_0080);
        pin_exp(4'h0, 1, "R6");
        rd_chk(16'h1808, 32'h0, "R3");

        // R7: groups with invalid pin bytes drive nothing
        wr(16'h1614, 32'hFFFF_FFFF);
        wr(16'h1618, 32'hFFFF_FFFF);
        wr(16'h1610, 32'hFFFF_FFFF);
        vec_up(161);
        vec_up(200);
        pin_exp(4'h0, 2, "R7");
        rd_chk(16'h1814, 32'h0000_0002, "R2");
        rd_chk(16'h1818, 32'h0000_0100, "R2");
        vec_up(129);
        pin_exp(4'h1, 2, "R7");
        wr(16'h1810, 32'h0000_0002);
        pin_exp(4'h0, 1, "R7");

        // R6: two groups to two pins at once
        wr(16'h1604, 32'hFFFF_FFFF);
        wr(16'h160C, 32'hFFFF_FFFF);
        @(negedge clk);
        vec_in[40] = 1'b1;
        vec_in[100] = 1'b1;
        pin_exp(4'hA, 2, "R6");

        // R8: storage words
        wr(16'h1684, 32'hA5A5_0001);
        pin_exp(4'hA, 1, "R8");
        rd_chk(16'h1684, 32'hA5A5_0001, "R8");
        rd_chk(16'h1680, 32'h0, "R8");

        // R9: unmapped and misaligned offsets
        wr(16'h1700, 32'hFFFF_FFFF);
        rd_chk(16'h1700, 32'h0, "R9");
        wr(16'h1620, 32'hFFFF_FFFF);
        rd_chk(16'h1620, 32'h0, "R9");
        rd_chk(16'h1602, 32'h0, "R9");
        rd_chk(16'h14C8, 32'h0, "R9");
        wr(16'h1601, 32'h0);
        rd_chk(16'h1600, 32'hFFFF_FFFF, "R9");
        pin_exp(4'hA, 1, "R9");

        // R7: retarget group 3 to pin 0
        wr(16'h14C0, 32'h0104_0201);
        pin_exp(4'h3, 1, "R7");

        // R3: clear everything still pending on the driven pins
        wr(16'h1804, 32'hFFFF_FFFF);
        wr(16'h180C, 32'hFFFF_FFFF);
        pin_exp(4'h0, 1, "R3");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard %0d items never due, actual=%0d expected=0",
                     sb_q.size(), sb_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule